// File: doc/BRIEF.md
# Dual-Channel PWM Slice with Fractional Clock-Enable Divider

The block generates two pulse-width-modulated outputs from one shared 16-bit counter. The counter does not run on every clock. A fractional divider with 8 integer and 4 fraction bits sets how often it steps, and it steps only on the enable pulses that this divider produces. Each output has its own compare value and its own inversion bit. A mode bit picks the counting shape. In sawtooth counting the counter climbs to the top value and wraps to zero. In phase-correct counting it climbs to the top value and then comes back down. The phase-correct shape keeps every pulse centred in its period.

Software programs the slice through a small register-style write port. Two strobe inputs nudge the running phase. One inserts a single extra enable pulse and the other deletes one. Each strobe leaves a busy flag raised until its effect has taken place. The compare values and the top value are double-buffered, so a new setting never cuts a period short. The port carries configuration only. It has no data stream, so it uses a plain write strobe with no back-pressure.

Top module: `pwmx_slice`

## Requirements
- R1: An accumulator adds 16 every enabled cycle. When the sum reaches the divider value D (register 1, bits [11:0], 4 fraction bits), the accumulator emits a step and subtracts D. D below 16 is treated as 16. So D=16 steps every cycle, D=24 steps twice in three cycles and D=32 steps every other cycle, with the first step on the second enabled cycle.
- R2: Before inversion, each output is high exactly when its active compare value is greater than the current count.
- R3: A compare value of 0 keeps an uninverted output low. A compare value of TOP+1 keeps it high.
- R4: In sawtooth mode (control bit 1 = 0), each step moves the count up by one. From TOP or above, a step moves it to 0.
- R5: In phase-correct mode (control bit 1 = 1), the count runs 0,1,...,TOP,TOP-1,...,1,0,1,... and does not repeat a value at either turning point. The period is 2*TOP steps.
- R6: While the run bit (control bit 0) is 0, the count holds, the accumulator holds and both outputs are low.
- R7: Control bit 2 inverts output A and control bit 3 inverts output B, each independently of the other.
- R8: An advance strobe raises adv_busy. The next enabled cycle that has no natural step gains one step, and adv_busy then drops. The count never moves more than one step in a cycle.
- R9: A retard strobe raises ret_busy. The next natural step is deleted, and ret_busy then drops. While the run bit is 0 nothing is deleted, the count never goes backward and ret_busy stays high.
- R10: Writes to TOP (address 2), compare A (address 3) and compare B (address 4) take effect only when a step brings the count to 0. While the run bit is 0 they take effect on the next cycle.
- R11: Address 0 holds the control bits. Address 1 holds the divider, which takes effect at once and resets to 16. TOP resets to 0xFFFF and both compare values reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| adv_req | input | 1 | Phase-advance strobe |
| ret_req | input | 1 | Phase-retard strobe |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| count_o | output | 16 | Current counter value |
| adv_busy | output | 1 | Advance pending |
| ret_busy | output | 1 | Retard pending |

## Verification
The sawtooth tests run with TOP=4 and a unity divider. The phase-correct tests use the same top value. Comparing the two count sequences cycle by cycle separates the wrap from the reversal and exposes any value repeated at a turning point.

The divider is tried at 1.5, at 2.0 and at 0. The first shows that the fraction accumulates correctly. The second shows plain integer gating. The third shows the clamp of small values to 1.0.

The phase nudges are checked as a final count offset against a 2.0 divider. Under a unity divider there is no free cycle, so an advance must wait. A retard sent while the slice is stopped must leave the count alone.

A TOP change made mid-period, and compare values of 0, TOP+1 and an inverted channel, separate double-buffered loading and the output polarity from a plain comparator.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_DIV  = 3'd1;
  localparam logic [2:0] ADR_TOP  = 3'd2;
  localparam logic [2:0] ADR_CMPA = 3'd3;
  localparam logic [2:0] ADR_CMPB = 3'd4;

  typedef struct packed {
    logic inv_b;
    logic inv_a;
    logic phase_corr;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
  import pwmx_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 12,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [2:0]                addr,
  input  logic [CNT_W-1:0]          wdata,
  input  logic                      load_ev,
  output ctrl_t                     ctrl,
  output logic [DIV_W-1:0]          div,
  output logic [CNT_W-1:0]          top_act,
  output logic [NCH-1:0][CNT_W-1:0] cmp_act
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(16);

  logic [CNT_W-1:0]          top_sh;
  logic [NCH-1:0][CNT_W-1:0] cmp_sh;
  logic                      load_now;

  assign load_now = load_ev | ~ctrl.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      div    <= DIV_RST;
      top_sh <= '1;
    end else if (we) begin
      if (addr == ADR_CTRL) ctrl   <= ctrl_t'(wdata[3:0]);
      if (addr == ADR_DIV)  div    <= wdata[DIV_W-1:0];
      if (addr == ADR_TOP)  top_sh <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_act <= '1;
    else if (load_now) top_act <= top_sh;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    localparam logic [2:0] MY_ADR = ADR_CMPA + 3'(c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_sh[c]  <= '0;
        cmp_act[c] <= '0;
      end else begin
        if (we && addr == MY_ADR) cmp_sh[c] <= wdata;
        if (load_now) cmp_act[c] <= cmp_sh[c];
      end
    end
  end
endmodule

// File: rtl/pwmx_tickgen.sv
module pwmx_tickgen #(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             adv_req,
  input  logic             ret_req,
  output logic             tick,
  output logic             adv_pend,
  output logic             ret_pend
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1 << FRAC_W);

  logic [ACC_W-1:0] acc, sum, dv;
  logic             nat, adv_take, ret_take;

  assign dv       = {1'b0, (div < ONE) ? ONE : div};
  assign sum      = acc + ACC_W'(ONE);
  assign nat      = (sum >= dv);
  assign adv_take = run & ~nat & adv_pend;
  assign ret_take = run & nat & ret_pend;
  assign tick     = (run & nat & ~ret_pend) | adv_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (run) acc <= nat ? (sum - dv) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_pend <= 1'b0;
      ret_pend <= 1'b0;
    end else begin
      if (adv_req) adv_pend <= 1'b1;
      else if (adv_take) adv_pend <= 1'b0;
      if (ret_req) ret_pend <= 1'b1;
      else if (ret_take) ret_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pwmx_counter.sv
module pwmx_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             phase_corr,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             load_ev
);
  logic             down, nxt_down;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt      = cnt;
    nxt_down = down;
    load_ev  = 1'b0;
    if (tick) begin
      if (!phase_corr) begin
        nxt_down = 1'b0;
        if (cnt >= top) begin
          nxt     = '0;
          load_ev = 1'b1;
        end else begin
          nxt = cnt + 1'b1;
        end
      end else if (!down && cnt < top) begin
        nxt = cnt + 1'b1;
      end else if (cnt == '0) begin
        nxt_down = 1'b0;
        load_ev  = 1'b1;
      end else begin
        nxt      = cnt - 1'b1;
        nxt_down = 1'b1;
        if (cnt == CNT_W'(1)) begin
          nxt_down = 1'b0;
          load_ev  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      cnt  <= nxt;
      down <= nxt_down;
    end
  end
endmodule

// File: rtl/pwmx_slice.sv
module pwmx_slice
  import pwmx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             adv_req,
  input  logic             ret_req,
  output logic             out_a,
  output logic             out_b,
  output logic [CNT_W-1:0] count_o,
  output logic             adv_busy,
  output logic             ret_busy
);
  localparam int NCH = 2;

  ctrl_t                     ctrl;
  logic [DIV_W-1:0]          div;
  logic [CNT_W-1:0]          top_act, cnt;
  logic [NCH-1:0][CNT_W-1:0] cmp_act;
  logic [NCH-1:0]            inv, outs;
  logic                      tick, load_ev;

  pwmx_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .NCH(NCH)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load_ev(load_ev), .ctrl(ctrl), .div(div), .top_act(top_act), .cmp_act(cmp_act)
  );

  pwmx_tickgen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .div(div), .adv_req(adv_req),
    .ret_req(ret_req), .tick(tick), .adv_pend(adv_busy), .ret_pend(ret_busy)
  );

  pwmx_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase_corr(ctrl.phase_corr),
    .top(top_act), .cnt(cnt), .load_ev(load_ev)
  );

  assign inv = {ctrl.inv_b, ctrl.inv_a};

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign outs[c] = ctrl.run & (inv[c] ^ (cmp_act[c] > cnt));
  end

  assign out_a   = outs[0];
  assign out_b   = outs[1];
  assign count_o = cnt;
endmodule

// File: rtl/pwmx_slice_chk.sv
module pwmx_slice_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             pc,
  input logic             inv_a,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cnt,
  input logic             out_a,
  input logic             out_b,
  input logic             ret_busy
);
  AST_ONE_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1 || cnt == '0)); // R8

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == $past(cnt)); // R6

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!out_a && !out_b)); // R6

  AST_CMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_a == '0) |-> out_a == inv_a); // R3

  AST_SAW_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc && $past(!pc) && cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0)); // R4

  AST_RETARD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && ret_busy) |=> ret_busy); // R9
endmodule

bind pwmx_slice pwmx_slice_chk #(.CNT_W(CNT_W)) i_pwmx_slice_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl.run), .pc(ctrl.phase_corr), .inv_a(ctrl.inv_a),
  .cmp_a(cmp_act[0]), .cnt(cnt), .out_a(out_a), .out_b(out_b), .ret_busy(ret_busy)
);

// File: tb/test_pwmx_slice.sv
module test_pwmx_slice;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        adv_req = 1'b0;
  logic        ret_req = 1'b0;
  logic        out_a, out_b, adv_busy, ret_busy;
  logic [15:0] count_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmx_slice i_pwmx_slice (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .adv_req(adv_req), .ret_req(ret_req), .out_a(out_a), .out_b(out_b),
    .count_o(count_o), .adv_busy(adv_busy), .ret_busy(ret_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input int top, input int ca, input int cb, input int dv);
    do_reset();
    wr(3'd2, 16'(top));
    wr(3'd3, 16'(ca));
    wr(3'd4, 16'(cb));
    wr(3'd1, 16'(dv));
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 reset count", int'(count_o), 0);
    check("R6 reset out_a", int'(out_a), 0);
    check("R6 reset out_b", int'(out_b), 0);
    check("R8 reset adv_busy", int'(adv_busy), 0);
  endtask

  task automatic t_sawtooth();
    setup(4, 2, 5, 16);
    wr(3'd0, 16'h1);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R4 saw count", int'(count_o), k % 5);
      check("R2 out_a", int'(out_a), int'((k % 5) < 2));
      check("R3 cmp TOP+1 high", int'(out_b), 1);
    end
  endtask

  task automatic t_invert();
    setup(4, 2, 0, 16);
    wr(3'd0, 16'h5);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R7 inverted out_a", int'(out_a), int'(!((k % 5) < 2)));
      check("R3 cmp zero low", int'(out_b), 0);
    end
  endtask

  task automatic t_phase();
    setup(4, 2, 0, 16);
    wr(3'd0, 16'h3);
    for (int k = 1; k <= 17; k++) begin
      int p, e;
      @(negedge clk);
      p = k % 8;
      e = (p <= 4) ? p : 8 - p;
      check("R5 phase count", int'(count_o), e);
      check("R5 phase out_a", int'(out_a), int'(e < 2));
    end
  endtask

  task automatic t_div(input int dv);
    setup(1000, 0, 0, dv);
    wr(3'd0, 16'h1);
    for (int k = 1; k <= 12; k++) begin
      int e;
      @(negedge clk);
      if (dv == 24) e = k - (k + 2) / 3;
      else if (dv == 32) e = k / 2;
      else e = k;
      check("R1 divider count", int'(count_o), e);
    end
  endtask

  task automatic t_advance();
    setup(1000, 0, 0, 32);
    wr(3'd0, 16'h1);
    for (int k = 1; k <= 20; k++) begin
      if (k == 3) begin
        adv_req = 1'b1; @(negedge clk); adv_req = 1'b0;
        check("R8 adv busy raised", int'(adv_busy), 1);
      end else @(negedge clk);
    end
    check("R8 advance offset", int'(count_o), 11);
    check("R8 adv busy cleared", int'(adv_busy), 0);
    setup(1000, 0, 0, 16);
    wr(3'd0, 16'h1);
    adv_req = 1'b1; @(negedge clk); adv_req = 1'b0;
    repeat (9) @(negedge clk);
    check("R8 one step per cycle", int'(count_o), 10);
    check("R8 adv waits for free cycle", int'(adv_busy), 1);
  endtask

  task automatic t_retard();
    setup(1000, 0, 0, 32);
    wr(3'd0, 16'h1);
    for (int k = 1; k <= 20; k++) begin
      if (k == 3) begin
        ret_req = 1'b1; @(negedge clk); ret_req = 1'b0;
      end else @(negedge clk);
    end
    check("R9 retard offset", int'(count_o), 9);
    check("R9 ret busy cleared", int'(ret_busy), 0);
    setup(1000, 3, 3, 16);
    wr(3'd0, 16'h1);
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h0);
    check("R6 count held value", int'(count_o), 6);
    ret_req = 1'b1; @(negedge clk); ret_req = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 no backward when stopped", int'(count_o), 6);
    check("R9 ret busy kept", int'(ret_busy), 1);
    check("R6 stopped out_a low", int'(out_a), 0);
  endtask

  task automatic t_dbuf();
    setup(9, 0, 0, 16);
    wr(3'd0, 16'h1);
    for (int k = 1; k <= 15; k++) begin
      if (k == 4) begin
        cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 16'd4;
        @(negedge clk);
        cfg_we = 1'b0;
      end else @(negedge clk);
      if (k == 8)  check("R10 old TOP still active", int'(count_o), 8);
      if (k == 10) check("R10 wrap at old TOP", int'(count_o), 0);
      if (k == 14) check("R10 new TOP reached", int'(count_o), 4);
      if (k == 15) check("R10 wrap at new TOP", int'(count_o), 0);
    end
  endtask

  initial begin
    t_reset();
    t_sawtooth();
    t_invert();
    t_phase();
    t_div(24);
    t_div(32);
    t_div(0);
    t_advance();
    t_retard();
    t_dbuf();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule